// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block watches a bank of asynchronous request lines. Each line is brought into the clock domain, then compared with its own previous value to find edges. Each line has its own rising and falling enable, so it can react to rising edges, falling edges, both, or neither. A qualified edge sets that line's pending bit when the line's interrupt enable is on. The per-line interrupt output stays high until software clears the bit. The same edge also produces a single-cycle event pulse when the line's event enable is on. The event path has no pending state.

Software uses one synchronous write port. A select code picks one of six write targets: the four configuration vectors, a software-trigger vector and a write-one-to-clear pending vector. Setting a software-trigger bit acts like an edge on that line and feeds the same pending and event paths as a hardware edge. The bit clears itself when the line's pending bit is cleared.

Top module: `ext_irq_edge_ctrl`

## Requirements
- R1: After reset every enable, pending, software-trigger and event bit is 0, so `irq_o` and `evt_o` are 0. With all enables still 0, toggling an input raises nothing.
- R2: Write-port select codes: 0 rising enables, 1 falling enables, 2 interrupt enables, 3 event enables, 4 software trigger, 5 pending clear. Bit i of `wr_data` addresses line i. With the rising enable set, a 0-to-1 change on `ext_in[i]` sets the line's pending bit. With a falling change, the rising enable alone sets nothing.
- R3: With only the falling enable set, a 1-to-0 change sets the pending bit, and a 0-to-1 change does not.
- R4: With both enables set, either direction of change sets the pending bit.
- R5: With both enables cleared, a line never triggers, whichever way it toggles.
- R6: A detected edge on a line whose interrupt enable is 0 leaves the pending bit clear. Enabling the interrupt later therefore shows `irq_o[i]` = 0. `irq_o` equals pending ANDed with the interrupt enable.
- R7: A detected edge on a line with its event enable set gives `evt_o[i]` = 1 for exactly one cycle. This does not depend on the interrupt enable.
- R8: Writing 1 to a pending-clear bit clears that bit. Writing 0 leaves it unchanged. `irq_o` falls at the write's clock edge.
- R9: When an edge is detected in the same cycle as a clear of that line's pending bit, the bit stays set.
- R10: Writing 1 to a software-trigger bit that is 0 sets the pending bit, if the interrupt is enabled, and pulses the event, if the event is enabled, at the write edge. The trigger bit clears when that line's pending bit is cleared. After that, a new write triggers again.
- R11: Lines are independent. An edge on one line affects only that line's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | NUM_LINES | Asynchronous request lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select code |
| wr_data | input | NUM_LINES | Write data, one bit per line |
| irq_o | output | NUM_LINES | Latched interrupt requests |
| evt_o | output | NUM_LINES | Single-cycle event pulses |

## Verification
A change on an input line passes through two synchronizer flops and one history flop. The resulting pending bit and event pulse appear just after the third rising clock edge that follows the change. A register write, including a software trigger or a clear, takes effect at the clock edge that samples it. The bench therefore drives inputs at a falling edge, waits exactly three rising edges or one write edge, and samples at the next falling edge. It then checks the event output one cycle later to confirm the pulse has ended. To make an edge and a clear meet in one cycle, the clear is timed so it is sampled on that same third rising edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    // Write-port target select codes
    typedef enum logic [2:0] {
        SEL_RISE     = 3'd0,
        SEL_FALL     = 3'd1,
        SEL_IRQ_EN   = 3'd2,
        SEL_EVT_EN   = 3'd3,
        SEL_SW       = 3'd4,
        SEL_PEND_CLR = 3'd5
    } reg_sel_e;

    localparam int SEL_W = 3;
endpackage

// File: rtl/ext_irq_cfg_regs.sv
module ext_irq_cfg_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] rise_en,
    output logic [NUM_LINES-1:0] fall_en,
    output logic [NUM_LINES-1:0] irq_en,
    output logic [NUM_LINES-1:0] evt_en
);
    typedef struct packed {
        logic [NUM_LINES-1:0] rise;
        logic [NUM_LINES-1:0] fall;
        logic [NUM_LINES-1:0] irq;
        logic [NUM_LINES-1:0] evt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_RISE:   cfg_d.rise = wr_data;
                SEL_FALL:   cfg_d.fall = wr_data;
                SEL_IRQ_EN: cfg_d.irq  = wr_data;
                SEL_EVT_EN: cfg_d.evt  = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rise_en = cfg_q.rise;
    assign fall_en = cfg_q.fall;
    assign irq_en  = cfg_q.irq;
    assign evt_en  = cfg_q.evt;
endmodule

// File: rtl/ext_irq_edge_det.sv
module ext_irq_edge_det #(
    parameter int NUM_LINES = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] din,
    input  logic [NUM_LINES-1:0] rise_en,
    input  logic [NUM_LINES-1:0] fall_en,
    output logic [NUM_LINES-1:0] hit_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] meta;
        logic [NUM_LINES-1:0] sync;
        logic [NUM_LINES-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = din;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Qualified edge, one bit per line
    assign hit_o = (s_q.sync & ~s_q.prev & rise_en) |
                   (~s_q.sync & s_q.prev & fall_en);
endmodule

// File: rtl/ext_irq_edge_ctrl.sv
module ext_irq_edge_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_in,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] irq_o,
    output logic [NUM_LINES-1:0] evt_o
);
    logic [NUM_LINES-1:0] rise_en, fall_en, irq_en, evt_en, hit;
    logic [NUM_LINES-1:0] sw_wr, clr_w, sw_edge, trig_w, set_w;

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] sw;
        logic [NUM_LINES-1:0] evt;
    } state_t;

    state_t st_d, st_q;

    ext_irq_cfg_regs #(.NUM_LINES(NUM_LINES)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .irq_en  (irq_en),
        .evt_en  (evt_en)
    );

    ext_irq_edge_det #(.NUM_LINES(NUM_LINES)) i_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (ext_in),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .hit_o   (hit)
    );

    always_comb begin
        sw_wr   = (wr_en && wr_sel == SEL_SW)       ? wr_data : '0;
        clr_w   = (wr_en && wr_sel == SEL_PEND_CLR) ? wr_data : '0;
        sw_edge = sw_wr & ~st_q.sw;
        trig_w  = hit | sw_edge;
        set_w   = trig_w & irq_en;

        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_w) | set_w;
        st_d.sw   = (st_q.sw & ~clr_w) | sw_wr;
        st_d.evt  = trig_w & evt_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.pend & irq_en;
    assign evt_o = st_q.evt;

    // R8
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_w & ~set_w)) |=> ((st_q.pend & $past(clr_w & ~set_w)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_w) |=> ((st_q.pend & $past(set_w)) == $past(set_w)));

    // R6
    pend_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(st_q.pend) & ~$past(set_w)) == '0));

    // R7
    evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_o & ~$past(evt_en)) == '0));

    // R10
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_w) |=> ((st_q.sw & $past(clr_w)) == '0));
endmodule

// File: tb/test_ext_irq_edge_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_edge_ctrl;
    import ext_irq_pkg::*;
    localparam int N = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ext_in = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [N-1:0]  wr_data = '0;
    logic [N-1:0]  irq_o, evt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    localparam logic [N-1:0] ONE  = 1;
    localparam logic [N-1:0] ALL1 = '1;

    always #2 clk = ~clk;

    ext_irq_edge_ctrl #(.NUM_LINES(N)) i_ext_irq_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_o(irq_o), .evt_o(evt_o)
    );

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive_line(input int line, input logic val);
        @(negedge clk);
        ext_in[line] = val;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "irq in reset", irq_o, '0);
        check("R1", "evt in reset", evt_o, '0);
        rst_n = 1'b1;
        drive_line(4, 1'b1);
        check("R1", "irq enables off", irq_o, '0);
        check("R1", "evt enables off", evt_o, '0);
        drive_line(4, 1'b0);

        wr(SEL_IRQ_EN, ALL1);
        wr(SEL_EVT_EN, ALL1);

        // Sweep every line over all four edge modes
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic [N-1:0] b;
                logic [N-1:0] er, ef;
                string tg;
                b  = ONE << i;
                er = m[0] ? b : '0;
                ef = m[1] ? b : '0;
                tg = (m == 0) ? "R5" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
                wr(SEL_RISE, er);
                wr(SEL_FALL, ef);
                wr(SEL_PEND_CLR, ALL1);
                drive_line(i, 1'b1);
                check(tg, "irq after rise", irq_o, er);
                check(tg, "evt after rise", evt_o, er);
                @(negedge clk);
                check("R7", "evt one cycle", evt_o, '0);
                wr(SEL_PEND_CLR, ALL1);
                drive_line(i, 1'b0);
                check(tg, "irq after fall", irq_o, ef);
                check(tg, "evt after fall", evt_o, ef);
                @(negedge clk);
                check("R7", "evt one cycle", evt_o, '0);
                wr(SEL_PEND_CLR, ALL1);
            end
        end

        // R11: two lines, different modes, changing together
        wr(SEL_RISE, ONE << 0);
        wr(SEL_FALL, ONE << 1);
        @(negedge clk);
        ext_in[1:0] = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "only rising line", irq_o, ONE << 0);
        wr(SEL_PEND_CLR, ALL1);
        @(negedge clk);
        ext_in[1:0] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "only falling line", irq_o, ONE << 1);
        wr(SEL_PEND_CLR, ALL1);

        // R6: interrupt disabled, event still fires
        wr(SEL_RISE, ONE << 3);
        wr(SEL_IRQ_EN, ALL1 & ~(ONE << 3));
        drive_line(3, 1'b1);
        check("R6", "masked irq", irq_o, '0);
        check("R7", "evt with irq masked", evt_o, ONE << 3);
        wr(SEL_IRQ_EN, ALL1);
        check("R6", "no pending after unmask", irq_o, '0);
        drive_line(3, 1'b0);

        // R8: write-one-to-clear
        wr(SEL_RISE, ONE << 5);
        drive_line(5, 1'b1);
        check("R8", "pending set", irq_o, ONE << 5);
        wr(SEL_PEND_CLR, ALL1 & ~(ONE << 5));
        check("R8", "zero write keeps", irq_o, ONE << 5);
        wr(SEL_PEND_CLR, ONE << 5);
        check("R8", "one write clears", irq_o, '0);
        drive_line(5, 1'b0);

        // R9: edge and clear in the same cycle
        wr(SEL_RISE, ONE << 2);
        wr(SEL_FALL, ONE << 2);
        drive_line(2, 1'b1);
        check("R4", "pending before race", irq_o, ONE << 2);
        @(negedge clk);
        ext_in[2] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = SEL_PEND_CLR; wr_data = ONE << 2;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check("R9", "set wins over clear", irq_o, ONE << 2);
        wr(SEL_PEND_CLR, ONE << 2);
        check("R8", "clear after race", irq_o, '0);
        wr(SEL_RISE, '0);
        wr(SEL_FALL, '0);

        // R10: software trigger
        wr(SEL_SW, ONE << 7);
        check("R10", "sw sets pending", irq_o, ONE << 7);
        check("R10", "sw event pulse", evt_o, ONE << 7);
        @(negedge clk);
        check("R10", "sw event ends", evt_o, '0);
        wr(SEL_PEND_CLR, ONE << 7);
        check("R10", "sw pending cleared", irq_o, '0);
        wr(SEL_SW, ONE << 7);
        check("R10", "sw retriggers after clear", irq_o, ONE << 7);
        wr(SEL_PEND_CLR, ONE << 7);
        wr(SEL_IRQ_EN, ALL1 & ~(ONE << 9));
        wr(SEL_SW, ONE << 9);
        check("R10", "sw masked no irq", irq_o, '0);
        check("R10", "sw masked event", evt_o, ONE << 9);
        wr(SEL_IRQ_EN, ALL1);
        check("R10", "sw masked no pending", irq_o, '0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule